// File: doc/BRIEF.md
# Secure Block-Lookup Configuration Register Bank

This block is the configuration register bank of a memory protection controller. A 32-bit memory-mapped register bus with byte enables and a per-access non-secure flag reaches a control register and a lookup table with one security bit per memory block. The table sits behind an index pointer. There is no direct window onto it. The bank also holds an interrupt-enable bit and reports the table size and the block-size code. A run of read-only identification bytes sits at the top of the 4 KiB register window.

The bank takes a request on any cycle with `req_valid` high and never stalls (there is no back-pressure). Exactly one cycle later `rsp_valid` goes high for one cycle and `rsp_rdata` carries the read result; for a write it carries zero. The access filter has a separate combinational read port (`lk_idx`/`lk_word`) for fetching any table word. It also receives the bus-error-response, lockdown and interrupt-enable bits as plain outputs.

Software normally loads the table in one of two ways: it sets the index once and streams full-word writes with auto-increment on, or it writes the index before each word. It then sets lockdown, which freezes the security map until the next reset.

Top module: `sec_lut_regbank`

## Requirements
- R1: After reset the following values hold:
  - The control register reads 0x00000100, so auto-increment is on.
  - The index reads 0.
  - Every table word is 0.
  - The interrupt enable (offset 0x28, bit 0) reads 1.
- R2: The control register is at offset 0x00 and has three writable bits:
  - bit 4 is the error response, exported on `err_resp_o`;
  - bit 8 is auto-increment;
  - bit 31 is lockdown, exported on `lockdown_o`.
  All other control bits read zero and ignore writes.
- R3: Two read-only registers report geometry, and writes to both have no effect:
  - offset 0x10 reads NUM_WORDS-1;
  - offset 0x14 reads BLK_CODE, which is log2 of the block size in bytes minus 5.
- R4: The index register is at offset 0x18. A write stores the written value modulo NUM_WORDS, so the index never reaches NUM_WORDS.
- R5: Offset 0x1C reads or writes the table word selected by the index.
  - The index advances by one after an access only if all four byte enables are set and auto-increment is on.
  - The index wraps from NUM_WORDS-1 to 0.
  - Narrower accesses never move the index.
- R6: Lockdown persists until reset. While it is set:
  - writes to control, table data and interrupt enable are ignored;
  - an ignored table write does not advance the index;
  - index writes and table reads still work.
- R7: A non-secure access (`req_nonsec`=1) below offset 0xFD0 has no side effect and returns zero. This holds for reads and writes, including index advance.
- R8: Identification word i sits at offset 0xFD0+4*i, for i from 0 to 11.
  - It reads bits [8*i+7:8*i] of ID_BYTES, zero-extended.
  - Any master, secure or not, can read it.
  - Writes to it are ignored.
- R9: A write with some byte enables clear is handled in one of two ways:
  - for control, index and table data, it keeps the disabled byte lanes at their current contents;
  - for every other register, disabled lanes count as zero, so a lane-1-only write to offset 0x28 clears the enable.
- R10: Unknown offsets and write-only offsets (for example 0x24, 0x34) read zero. A read returns only the byte lanes whose enable is set, in place, with the other lanes zero.
- R11: `lk_word` equals table word `lk_idx` in the same cycle. It reads zero when `lk_idx` is NUM_WORDS or more. A table write shows on it from the cycle after the write.
- R12: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high, and `rsp_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nonsec | input | 1 | Access is from a non-secure master |
| req_addr | input | 12 | Byte offset in the register window |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| lk_idx | input | IDXW | Table word index from the access filter |
| lk_word | output | 32 | Table word at `lk_idx` |
| err_resp_o | output | 1 | Blocked accesses should get a bus error |
| lockdown_o | output | 1 | Configuration is locked |
| irq_en_o | output | 1 | Interrupt enable |

## Verification
The bench uses a five-word table, so the modulo and wrap logic cannot rely on power-of-two masking. A design that truncated the index instead of reducing it would read back 5, 6 or 7 from the index sweep and break the wrap after word four.

Auto-increment is probed with narrow accesses, with the enable off, and with a table write blocked by lockdown. An advance in any of these cases shifts every later streamed word by one slot.

Partial writes are aimed at the merging registers and at the zero-extending enable register. Mixing up the two policies either wipes neighbouring table bytes or leaves the interrupt enable set.

Non-secure accesses are swept over every configuration offset. A leak shows as non-zero data, a set lockdown or a moved index.

// File: rtl/slr_pkg.sv
package slr_pkg;

  // Word offsets (byte offset / 4) inside the 4 KiB register window.
  localparam logic [9:0] W_CTRL    = 10'h000;
  localparam logic [9:0] W_NWORDS  = 10'h004;
  localparam logic [9:0] W_BCODE   = 10'h005;
  localparam logic [9:0] W_INDEX   = 10'h006;
  localparam logic [9:0] W_TABLE   = 10'h007;
  localparam logic [9:0] W_IRQEN   = 10'h00A;
  localparam logic [9:0] W_ID_BASE = 10'h3F4;

  // Control register bit positions.
  localparam int CB_RESP = 4;
  localparam int CB_INC  = 8;
  localparam int CB_LOCK = 31;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_NWORDS, SEL_BCODE,
    SEL_INDEX, SEL_TABLE, SEL_IRQEN, SEL_ID
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [3:0] id_slot;
    logic       blocked;
  } dec_t;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [31:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/slr_decode.sv
module slr_decode
  import slr_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        nonsec,
  output dec_t        dec
);
  logic [9:0] word;
  assign word = addr[11:2];

  always_comb begin
    dec = '{sel: SEL_NONE, id_slot: 4'd0, blocked: 1'b0};
    dec.blocked = nonsec && (word < W_ID_BASE);
    case (word)
      W_CTRL:   dec.sel = SEL_CTRL;
      W_NWORDS: dec.sel = SEL_NWORDS;
      W_BCODE:  dec.sel = SEL_BCODE;
      W_INDEX:  dec.sel = SEL_INDEX;
      W_TABLE:  dec.sel = SEL_TABLE;
      W_IRQEN:  dec.sel = SEL_IRQEN;
      default: begin
        if (word >= W_ID_BASE) begin
          dec.sel     = SEL_ID;
          dec.id_slot = 4'(word - W_ID_BASE);
        end
      end
    endcase
  end
endmodule

// File: rtl/slr_index.sv
module slr_index #(
  parameter int NUM_WORDS = 4,
  parameter int IDXW      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [31:0]     load_val,
  input  logic            step,
  output logic [IDXW-1:0] idx
);
  logic [31:0]     reduced;
  logic [IDXW-1:0] next_up;

  assign reduced = load_val % 32'(NUM_WORDS);
  assign next_up = (idx == IDXW'(NUM_WORDS - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= reduced[IDXW-1:0];
    else if (step) idx <= next_up;
  end
endmodule

// File: rtl/slr_table.sv
module slr_table #(
  parameter int NUM_WORDS = 4,
  parameter int IDXW      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [31:0]     rd_data_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [31:0]     rd_data_b
);
  logic [31:0] flat [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              w_q <= '0;
      else if (wr_en && wr_idx == IDXW'(g))    w_q <= wr_data;
    end
    assign flat[g] = w_q;
  end

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_idx_a == IDXW'(i)) rd_data_a = flat[i];
      if (rd_idx_b == IDXW'(i)) rd_data_b = flat[i];
    end
  end
endmodule

// File: rtl/sec_lut_regbank.sv
module sec_lut_regbank
  import slr_pkg::*;
#(
  parameter int          NUM_WORDS = 4,
  parameter int          BLK_CODE  = 7,
  parameter logic [95:0] ID_BYTES  = 96'h5AE107C3_004B9231_00000002,
  localparam int         IDXW      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_nonsec,
  input  logic [11:0]     req_addr,
  input  logic [3:0]      req_be,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata,
  input  logic [IDXW-1:0] lk_idx,
  output logic [31:0]     lk_word,
  output logic            err_resp_o,
  output logic            lockdown_o,
  output logic            irq_en_o
);
  dec_t            dec;
  logic [31:0]     mask;
  logic            full_word, acc, wr, rd;
  logic            resp_q, inc_q, lock_q, irq_en_q;
  logic [31:0]     ctrl_word, ctrl_next, cur_word, rmux;
  logic [IDXW-1:0] idx_q;
  logic            idx_load, idx_step, tbl_we;
  logic [31:0]     idx_merged, tbl_merged;

  slr_decode u_dec (.addr(req_addr), .nonsec(req_nonsec), .dec(dec));

  assign mask      = lane_mask(req_be);
  assign full_word = (req_be == 4'hF);
  assign acc       = req_valid && !dec.blocked;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_RESP] = resp_q;
    ctrl_word[CB_INC]  = inc_q;
    ctrl_word[CB_LOCK] = lock_q;
  end
  assign ctrl_next = merge_lanes(ctrl_word, req_wdata, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q   <= 1'b0;
      inc_q    <= 1'b1;
      lock_q   <= 1'b0;
      irq_en_q <= 1'b1;
    end else if (wr && !lock_q) begin
      if (dec.sel == SEL_CTRL) begin
        resp_q <= ctrl_next[CB_RESP];
        inc_q  <= ctrl_next[CB_INC];
        lock_q <= ctrl_next[CB_LOCK];
      end
      if (dec.sel == SEL_IRQEN) irq_en_q <= req_wdata[0] & mask[0];
    end
  end

  // Index pointer
  assign idx_merged = merge_lanes(32'(idx_q), req_wdata, mask);
  assign idx_load   = wr && (dec.sel == SEL_INDEX);
  assign idx_step   = acc && (dec.sel == SEL_TABLE) && full_word && inc_q &&
                      (!req_write || !lock_q);

  slr_index #(.NUM_WORDS(NUM_WORDS), .IDXW(IDXW)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .load_val(idx_merged),
    .step(idx_step), .idx(idx_q)
  );

  // Lookup table
  assign tbl_we     = wr && (dec.sel == SEL_TABLE) && !lock_q;
  assign tbl_merged = merge_lanes(cur_word, req_wdata, mask);

  slr_table #(.NUM_WORDS(NUM_WORDS), .IDXW(IDXW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(idx_q),
    .wr_data(tbl_merged), .rd_idx_a(idx_q), .rd_data_a(cur_word),
    .rd_idx_b(lk_idx), .rd_data_b(lk_word)
  );

  // Read mux and response
  always_comb begin
    case (dec.sel)
      SEL_CTRL:   rmux = ctrl_word;
      SEL_NWORDS: rmux = 32'(NUM_WORDS - 1);
      SEL_BCODE:  rmux = 32'(BLK_CODE);
      SEL_INDEX:  rmux = 32'(idx_q);
      SEL_TABLE:  rmux = cur_word;
      SEL_IRQEN:  rmux = {31'b0, irq_en_q};
      SEL_ID:     rmux = {24'b0, ID_BYTES[{dec.id_slot, 3'b000} +: 8]};
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd ? (rmux & mask) : '0;
    end
  end

  assign err_resp_o = resp_q;
  assign lockdown_o = lock_q;
  assign irq_en_o   = irq_en_q;
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
  parameter int NUM_WORDS = 4,
  parameter int IDXW      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            req_nonsec,
  input logic [11:0]     req_addr,
  input logic [3:0]      req_be,
  input logic            rsp_valid,
  input logic            err_resp_o,
  input logic            lockdown_o,
  input logic            irq_en_o,
  input logic [IDXW-1:0] cur_idx
);
  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx < IDXW'(NUM_WORDS) || NUM_WORDS == (1 << IDXW));
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown_o |=> lockdown_o);
  assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown_o |=> ($stable(irq_en_o) && $stable(err_resp_o)));
  assert_ns_noeffect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonsec && req_addr[11:2] < 10'h3F4) |=>
      ($stable(cur_idx) && $stable(irq_en_o) && $stable(err_resp_o) &&
       $stable(lockdown_o)));
  assert_narrow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_be != 4'hF && req_addr[11:2] == 10'h007) |=>
      $stable(cur_idx));
  assert_write_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind sec_lut_regbank slr_checker #(.NUM_WORDS(NUM_WORDS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_nonsec(req_nonsec), .req_addr(req_addr), .req_be(req_be),
  .rsp_valid(rsp_valid), .err_resp_o(err_resp_o), .lockdown_o(lockdown_o),
  .irq_en_o(irq_en_o), .cur_idx(idx_q)
);

// File: tb/tb_sec_lut_regbank.sv
`timescale 1ns/1ps
module tb_sec_lut_regbank;
  localparam int          NW   = 5;
  localparam int          BC   = 3;
  localparam int          IW   = 3;
  localparam logic [95:0] IDB  = 96'h5AE107C3_004B9231_00000002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_nonsec = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [3:0]    req_be = 4'hF;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [IW-1:0] lk_idx = '0;
  logic [31:0]   lk_word;
  logic          err_resp_o, lockdown_o, irq_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [NW];
  logic [31:0] r;

  always #4 clk = ~clk;

  sec_lut_regbank #(.NUM_WORDS(NW), .BLK_CODE(BC), .ID_BYTES(IDB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_nonsec(req_nonsec), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lk_idx(lk_idx), .lk_word(lk_word), .err_resp_o(err_resp_o),
    .lockdown_o(lockdown_o), .irq_en_o(irq_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic ns, output logic [31:0] rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_be = be; req_nonsec = ns;
    @(negedge clk);
    rv = rsp_rdata;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic wrs(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    acc(1'b1, a, d, 4'hF, 1'b0, dummy);
  endtask

  task automatic rds(input logic [11:0] a, output logic [31:0] rv);
    acc(1'b0, a, 32'h0, 4'hF, 1'b0, rv);
  endtask

  task automatic look(input int i, input logic [31:0] exp, input string tag);
    @(negedge clk);
    lk_idx = IW'(i);
    #1;
    chk(tag, lk_word, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NW; i++) mdl[i] = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rds(12'h000, r); chk("R1 ctrl", r, 32'h100);
    rds(12'h018, r); chk("R1 index", r, 0);
    rds(12'h028, r); chk("R1 irq_en", r, 1);
    chk("R1 irq_en_o", {31'b0, irq_en_o}, 1);
    for (int i = 0; i < NW; i++) look(i, 0, "R1 table word");
    @(negedge clk);
    chk("R12 idle", {31'b0, rsp_valid}, 0);

    // R3 geometry
    rds(12'h010, r); chk("R3 nwords", r, NW - 1);
    rds(12'h014, r); chk("R3 bcode", r, BC);
    wrs(12'h010, 32'hFFFF_FFFF); wrs(12'h014, 32'hFFFF_FFFF);
    rds(12'h010, r); chk("R3 nwords after write", r, NW - 1);
    rds(12'h014, r); chk("R3 bcode after write", r, BC);

    // R2 control bits
    wrs(12'h000, 32'h7FFF_FFFF);
    rds(12'h000, r); chk("R2 ctrl mask", r, 32'h110);
    chk("R2 err_resp_o", {31'b0, err_resp_o}, 1);
    chk("R2 lockdown_o", {31'b0, lockdown_o}, 0);
    wrs(12'h000, 32'h100);
    chk("R2 err_resp_o clear", {31'b0, err_resp_o}, 0);

    // R4 index modulo sweep
    for (int v = 0; v < 13; v++) begin
      wrs(12'h018, 32'(v));
      rds(12'h018, r); chk("R4 index modulo", r, 32'(v % NW));
    end

    // R5 streamed writes with wrap
    wrs(12'h018, 0);
    for (int k = 0; k < 7; k++) begin
      logic [31:0] p;
      p = (32'h1000_0001 * 32'(k + 3)) ^ 32'h00A5_5A00;
      wrs(12'h01C, p);
      mdl[k % NW] = p;
    end
    rds(12'h018, r); chk("R5 index after wrap", r, 32'(7 % NW));
    for (int i = 0; i < 8; i++) look(i, (i < NW) ? mdl[i] : 32'h0, "R11 lookup port");
    wrs(12'h018, 0);
    for (int k = 0; k < 6; k++) begin
      rds(12'h01C, r); chk("R5 streamed read", r, mdl[k % NW]);
    end
    rds(12'h018, r); chk("R5 index after reads", r, 1);
    acc(1'b0, 12'h01C, 0, 4'h1, 1'b0, r); chk("R10 narrow table read", r, mdl[1] & 32'hFF);
    rds(12'h018, r); chk("R5 narrow no advance", r, 1);
    wrs(12'h000, 32'h0);
    rds(12'h01C, r); chk("R5 read no autoinc", r, mdl[1]);
    wrs(12'h01C, 32'h1234_5678); mdl[1] = 32'h1234_5678;
    rds(12'h018, r); chk("R5 index autoinc off", r, 1);
    look(1, mdl[1], "R11 lookup after write");
    wrs(12'h000, 32'h100);

    // R9 partial writes
    wrs(12'h018, 3);
    acc(1'b1, 12'h01C, 32'h0000_CD00, 4'h2, 1'b0, r);
    mdl[3] = (mdl[3] & 32'hFFFF_00FF) | 32'h0000_CD00;
    look(3, mdl[3], "R9 table merge");
    rds(12'h018, r); chk("R5 narrow write no advance", r, 3);
    acc(1'b1, 12'h018, 32'h0000_0100, 4'h2, 1'b0, r);
    rds(12'h018, r); chk("R9 index merge modulo", r, 32'(259 % NW));
    acc(1'b1, 12'h000, 32'h0000_0010, 4'h1, 1'b0, r);
    rds(12'h000, r); chk("R9 ctrl merge", r, 32'h110);
    acc(1'b1, 12'h028, 32'hFFFF_FFFF, 4'h2, 1'b0, r);
    chk("R9 irq_en zero-extend", {31'b0, irq_en_o}, 0);
    wrs(12'h028, 1);
    chk("R9 irq_en set", {31'b0, irq_en_o}, 1);

    // R10 unknown / write-only / narrow reads
    rds(12'h024, r); chk("R10 write-only 0x24", r, 0);
    rds(12'h034, r); chk("R10 write-only 0x34", r, 0);
    rds(12'h008, r); chk("R10 unknown 0x08", r, 0);
    rds(12'h800, r); chk("R10 unknown 0x800", r, 0);
    acc(1'b0, 12'h010, 0, 4'h2, 1'b0, r); chk("R10 lane1 of nwords", r, 0);
    acc(1'b0, 12'h010, 0, 4'h1, 1'b0, r); chk("R10 lane0 of nwords", r, NW - 1);
    acc(1'b0, 12'h000, 0, 4'h2, 1'b0, r); chk("R10 lane1 of ctrl", r, 32'h100);

    // R7 non-secure isolation
    wrs(12'h018, 2);
    for (int a = 0; a < 12; a++) begin
      acc(1'b0, 12'(a * 4), 0, 4'hF, 1'b1, r); chk("R7 ns read zero", r, 0);
    end
    acc(1'b0, 12'h028, 0, 4'hF, 1'b1, r); chk("R7 ns irq_en read", r, 0);
    acc(1'b1, 12'h000, 32'h8000_0000, 4'hF, 1'b1, r);
    chk("R7 ns ctrl write", {31'b0, lockdown_o}, 0);
    acc(1'b1, 12'h01C, 32'hFACE_FACE, 4'hF, 1'b1, r);
    look(2, mdl[2], "R7 ns table write");
    acc(1'b1, 12'h028, 32'h0, 4'hF, 1'b1, r);
    chk("R7 ns irq_en write", {31'b0, irq_en_o}, 1);
    rds(12'h018, r); chk("R7 ns no index advance", r, 2);

    // R8 identification space
    for (int i = 0; i < 12; i++) begin
      logic [31:0] e;
      e = {24'b0, IDB[8*i +: 8]};
      acc(1'b0, 12'(12'hFD0 + 4 * i), 0, 4'hF, 1'b0, r); chk("R8 id secure", r, e);
      acc(1'b0, 12'(12'hFD0 + 4 * i), 0, 4'hF, 1'b1, r); chk("R8 id nonsecure", r, e);
    end
    wrs(12'hFD4, 32'hFFFF_FFFF);
    rds(12'hFD4, r); chk("R8 id write ignored", r, {24'b0, IDB[15:8]});

    // R6 lockdown
    wrs(12'h000, 32'h8000_0110);
    chk("R6 lockdown_o", {31'b0, lockdown_o}, 1);
    wrs(12'h000, 32'h0);
    rds(12'h000, r); chk("R6 ctrl frozen", r, 32'h8000_0110);
    wrs(12'h028, 32'h0);
    chk("R6 irq_en frozen", {31'b0, irq_en_o}, 1);
    wrs(12'h018, 1);
    rds(12'h018, r); chk("R6 index still writable", r, 1);
    wrs(12'h01C, 32'hDEAD_BEEF);
    look(1, mdl[1], "R6 table frozen");
    rds(12'h018, r); chk("R6 blocked write no advance", r, 1);
    rds(12'h01C, r); chk("R6 table readable", r, mdl[1]);
    rds(12'h018, r); chk("R6 read advances", r, 2);

    do_reset();
    chk("R6 reset clears lockdown", {31'b0, lockdown_o}, 0);
    rds(12'h000, r); chk("R1 ctrl after reset", r, 32'h100);
    look(1, 0, "R1 table cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule